// File: doc/BRIEF.md
# Backplane Command Cycle Engine

This block carries out a single command cycle on a crate backplane. A requester hands it a station number, a subaddress, a function code and, for write functions, a data word. The engine puts the command on the backplane and holds it for a fixed window. When the strobe point in that window arrives, it samples the read data lines and the two response lines. It then takes the command off the bus and returns the sampled values with a one-cycle completion pulse.

The two response lines are returned as separate bits. The accept bit shows whether the addressed module recognised the command. The status bit has a meaning that depends on the module, and a block-transfer sequencer above this engine may use it as a continue/stop flag. Both windows are set as clock counts. With a 100 MHz clock, the defaults of 30 and 100 clocks give a 300 ns strobe point and a 1 µs command window. One cycle then completes about every 1.02 µs, which is close to one million cycles per second.

The function code is decoded by its two top bits. Codes 0..7 (top bits 00) are reads. Codes 16..23 (top bits 10) are writes. All other codes are control functions that move no data. Valid stations are 1 to 23.

Top module: `cmd_cycle_engine`

## Requirements
- R1: While reset is high and in the cycle after it is released, `req_ready` is 1, `done` is 0, and `bus_cmd` and `bus_wen` are 0.
- R2: `req_ready` is 1 only while the engine is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. Request inputs that change while a cycle is in flight have no effect on the bus or on the result.
- R3: For a request with a valid station, `bus_cmd` rises in the cycle after acceptance. `bus_station`, `bus_sub` and `bus_func` carry the request fields and stay unchanged while `bus_cmd` is 1.
- R4: The engine samples `bus_rdata`, `bus_x` and `bus_q` at the clock edge that ends the STROBE_CLKS-th cycle of `bus_cmd`. Values present before or after that edge have no effect on the result.
- R5: `bus_cmd` stays high for exactly CYCLE_CLKS cycles. `done` is a single-cycle pulse in the first cycle after `bus_cmd` falls.
- R6: For a write function (code 16..23, top two function bits 10), `bus_wen` is 1 and `bus_wdata` holds the request data for the whole time `bus_cmd` is high. Both are released with the command. For any other function, `bus_wen` and `bus_wdata` are 0.
- R7: For a read function (code 0..7, top two function bits 00), `done_rdata` returns the sampled read word. For write and control functions, `done_rdata` is 0.
- R8: A request for station 0 or for a station above 23 never raises `bus_cmd`. `done` pulses in the cycle after acceptance with `done_x`, `done_q` and `done_rdata` all 0.
- R9: `done_x` and `done_q` return the two sampled response lines independently, and all four combinations pass through unchanged.
- R10: `req_ready` returns to 1 in the cycle after the `done` pulse, so back-to-back requests start one cycle every CYCLE_CLKS+2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_station | input | 5 | Station number |
| req_sub | input | 4 | Subaddress |
| req_func | input | 5 | Function code |
| req_wdata | input | 24 | Write data |
| bus_cmd | output | 1 | Command is on the backplane |
| bus_station | output | 5 | Station number driven on the bus |
| bus_sub | output | 4 | Subaddress driven on the bus |
| bus_func | output | 5 | Function code driven on the bus |
| bus_wen | output | 1 | Write data lines are driven |
| bus_wdata | output | 24 | Write data lines |
| bus_rdata | input | 24 | Read data lines from the module |
| bus_x | input | 1 | Command-accepted response line |
| bus_q | input | 1 | Status response line |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 24 | Sampled read word |
| done_x | output | 1 | Sampled accept response |
| done_q | output | 1 | Sampled status response |

## Verification
An off-by-one in the cycle counter shows up in two ways. The first is the length of `bus_cmd`, which is seen at the first falling edge of the command. The second is the sampled values: the bench presents correct response values only for the one edge at the strobe point, so a shifted sample returns inverted data in the same cycle's `done`. A sequencer state that fails to leave idle or busy shows as `req_ready` high while the command is driven, or as a missing `done` pulse one cycle after release. A broken station check shows up on the very next cycle, as a command driven for an out-of-range station or as a nonzero accept bit on a rejected request. Write-data handling errors appear as `bus_wen` or `bus_wdata` values that differ from the request during the command window.

// File: rtl/cce_pkg.sv
package cce_pkg;

    localparam int STN_W       = 5;
    localparam int SUB_W       = 4;
    localparam int FN_W        = 5;
    localparam int DATA_W      = 24;
    localparam int STATION_TOP = 23;

    typedef struct packed {
        logic [STN_W-1:0]  station;
        logic [SUB_W-1:0]  sub;
        logic [FN_W-1:0]   func;
        logic [DATA_W-1:0] wdata;
    } cce_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              x;
        logic              q;
    } cce_resp_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FINISH = 2'd2
    } cce_state_t;

    typedef enum logic [1:0] {
        FC_READ    = 2'b00,
        FC_CTRL_LO = 2'b01,
        FC_WRITE   = 2'b10,
        FC_CTRL_HI = 2'b11
    } cce_fclass_t;

    function automatic cce_fclass_t func_class(input logic [FN_W-1:0] f);
        return cce_fclass_t'(f[FN_W-1 -: 2]);
    endfunction

    function automatic logic station_in_range(input logic [STN_W-1:0] s);
        return (s != '0) && (int'(s) <= STATION_TOP);
    endfunction

endpackage

// File: rtl/cce_decode.sv
module cce_decode
    import cce_pkg::*;
(
    input  logic [STN_W-1:0] station,
    input  logic [FN_W-1:0]  func,
    output logic             stn_ok,
    output logic             is_read,
    output logic             is_write
);
    cce_fclass_t cls;

    always_comb begin
        cls      = func_class(func);
        stn_ok   = station_in_range(station);
        is_read  = (cls == FC_READ);
        is_write = (cls == FC_WRITE);
    end
endmodule

// File: rtl/cce_timer.sv
module cce_timer #(
    parameter int STROBE_CLKS = 30,
    parameter int CYCLE_CLKS  = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic strobe_hit,
    output logic end_hit
);
    localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CLKS - 1);
    localparam logic [CNT_W-1:0] CYCLE_LAST  = CNT_W'(CYCLE_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != CYCLE_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        strobe_hit = run && (cnt == STROBE_LAST);
        end_hit    = run && (cnt == CYCLE_LAST);
    end

    // R4: the strobe point falls strictly before the end of the window
    a_r4_strobe_before_end: assert property (@(posedge clk) disable iff (rst)
        end_hit |-> !strobe_hit);
endmodule

// File: rtl/cce_bus_drive.sv
module cce_bus_drive
    import cce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              release_bus,
    input  cce_cmd_t          cmd,
    input  logic              is_write,
    output logic              active,
    output logic [STN_W-1:0]  station,
    output logic [SUB_W-1:0]  sub,
    output logic [FN_W-1:0]   func,
    output logic              wen,
    output logic [DATA_W-1:0] wdata
);
    always_ff @(posedge clk) begin
        if (rst || release_bus) begin
            active  <= 1'b0;
            station <= '0;
            sub     <= '0;
            func    <= '0;
            wen     <= 1'b0;
            wdata   <= '0;
        end else if (load) begin
            active  <= 1'b1;
            station <= cmd.station;
            sub     <= cmd.sub;
            func    <= cmd.func;
            wen     <= is_write;
            wdata   <= is_write ? cmd.wdata : '0;
        end
    end

    a_r3_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |->
            ($stable(station) && $stable(sub) && $stable(func)));

    a_r6_wdata_held: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> ($stable(wen) && $stable(wdata)));

    a_r6_wen_inside_cmd: assert property (@(posedge clk) disable iff (rst)
        wen |-> active);
endmodule

// File: rtl/cce_capture.sv
module cce_capture
    import cce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              is_read,
    input  logic [DATA_W-1:0] rdata,
    input  logic              x,
    input  logic              q,
    output cce_resp_t         resp
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            resp <= '0;
        end else if (sample) begin
            resp.rdata <= is_read ? rdata : '0;
            resp.x     <= x;
            resp.q     <= q;
        end
    end
endmodule

// File: rtl/cmd_cycle_engine.sv
module cmd_cycle_engine
    import cce_pkg::*;
#(
    parameter int STROBE_CLKS = 30,
    parameter int CYCLE_CLKS  = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [STN_W-1:0]  req_station,
    input  logic [SUB_W-1:0]  req_sub,
    input  logic [FN_W-1:0]   req_func,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bus_cmd,
    output logic [STN_W-1:0]  bus_station,
    output logic [SUB_W-1:0]  bus_sub,
    output logic [FN_W-1:0]   bus_func,
    output logic              bus_wen,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_x,
    input  logic              bus_q,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_x,
    output logic              done_q
);
    cce_state_t state;
    cce_cmd_t   req_cmd;
    cce_resp_t  resp;

    logic accept, req_stn_ok, req_is_read, req_is_write;
    logic drv_stn_ok, drv_is_read, drv_is_write;
    logic strobe_hit, end_hit, run;

    always_comb begin
        req_cmd   = '{station: req_station, sub: req_sub, func: req_func, wdata: req_wdata};
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        run       = (state == ST_ACTIVE);
    end

    cce_decode u_req_dec (
        .station (req_station),
        .func    (req_func),
        .stn_ok  (req_stn_ok),
        .is_read (req_is_read),
        .is_write(req_is_write)
    );

    cce_decode u_drv_dec (
        .station (bus_station),
        .func    (bus_func),
        .stn_ok  (drv_stn_ok),
        .is_read (drv_is_read),
        .is_write(drv_is_write)
    );

    cce_timer #(.STROBE_CLKS(STROBE_CLKS), .CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .strobe_hit(strobe_hit),
        .end_hit   (end_hit)
    );

    cce_bus_drive u_drive (
        .clk        (clk),
        .rst        (rst),
        .load       (accept && req_stn_ok),
        .release_bus(end_hit),
        .cmd        (req_cmd),
        .is_write   (req_is_write),
        .active     (bus_cmd),
        .station    (bus_station),
        .sub        (bus_sub),
        .func       (bus_func),
        .wen        (bus_wen),
        .wdata      (bus_wdata)
    );

    cce_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .sample (strobe_hit),
        .is_read(drv_is_read),
        .rdata  (bus_rdata),
        .x      (bus_x),
        .q      (bus_q),
        .resp   (resp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (accept) state <= req_stn_ok ? ST_ACTIVE : ST_FINISH;
                ST_ACTIVE: if (end_hit) state <= ST_FINISH;
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        done       = (state == ST_FINISH);
        done_rdata = resp.rdata;
        done_x     = resp.x;
        done_q     = resp.q;
    end

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        bus_cmd |-> !req_ready);

    a_r3_cmd_station_valid: assert property (@(posedge clk) disable iff (rst)
        bus_cmd |-> drv_stn_ok);

    a_r4_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
        strobe_hit |-> bus_cmd);

    a_r5_done_on_release: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_cmd) |-> done);

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_wen_matches_func: assert property (@(posedge clk) disable iff (rst)
        bus_cmd |-> (bus_wen == drv_is_write));

    a_r8_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_stn_ok) |=> (!bus_cmd && done && !done_x && !done_q));

    a_r10_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);
endmodule

// File: tb/cmd_cycle_engine_test.sv
module cmd_cycle_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int STROBE     = 30;
    localparam int CYCLE      = 100;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_station = '0;
    logic [3:0]  req_sub = '0;
    logic [4:0]  req_func = '0;
    logic [23:0] req_wdata = '0;
    logic        bus_cmd;
    logic [4:0]  bus_station;
    logic [3:0]  bus_sub;
    logic [4:0]  bus_func;
    logic        bus_wen;
    logic [23:0] bus_wdata;
    logic [23:0] bus_rdata = '0;
    logic        bus_x = 1'b0;
    logic        bus_q = 1'b0;
    logic        done;
    logic [23:0] done_rdata;
    logic        done_x;
    logic        done_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [25:0] exp_q[$];
    logic        prev_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_cycle_engine #(.STROBE_CLKS(STROBE), .CYCLE_CLKS(CYCLE)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_station(req_station), .req_sub(req_sub),
        .req_func(req_func), .req_wdata(req_wdata),
        .bus_cmd(bus_cmd), .bus_station(bus_station), .bus_sub(bus_sub),
        .bus_func(bus_func), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_x(bus_x), .bus_q(bus_q),
        .done(done), .done_rdata(done_rdata), .done_x(done_x), .done_q(done_q)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "WDOG", "run did not finish", cycles, WATCHDOG);
            finish_run();
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected done", 1, 0);
                end else begin
                    logic [25:0] e;
                    e = exp_q.pop_front();
                    check(done_rdata == e[25:2], "R7", "done_rdata", done_rdata, e[25:2]);
                    check(done_x == e[1], "R9", "done_x", done_x, e[1]);
                    check(done_q == e[0], "R9", "done_q", done_q, e[0]);
                end
                check(!prev_done, "R5", "done longer than one cycle", prev_done, 0);
            end
            prev_done = done;
        end
    end

    task automatic run_cycle(input logic [4:0] st, input logic [3:0] sa,
                             input logic [4:0] fn, input logic [23:0] wd,
                             input logic [23:0] rd, input logic x, input logic q);
        logic ok, rd_fn, wr_fn;
        ok    = (st != 0) && (st <= 23);
        rd_fn = (fn[4:3] == 2'b00);
        wr_fn = (fn[4:3] == 2'b10);
        @(negedge clk);
        check(req_ready, "R2", "ready before request", req_ready, 1);
        req_station = st; req_sub = sa; req_func = fn; req_wdata = wd;
        req_valid = 1'b1;
        bus_rdata = ~rd; bus_x = ~x; bus_q = ~q;
        exp_q.push_back({(ok && rd_fn) ? rd : 24'h0, ok ? x : 1'b0, ok ? q : 1'b0});
        @(negedge clk);
        // R2: scramble the request while busy; it must be ignored
        req_station = ~st; req_sub = ~sa; req_func = ~fn; req_wdata = ~wd;
        if (!ok) begin
            check(!bus_cmd, "R8", "bus driven for bad station", bus_cmd, 0);
            check(done, "R8", "done after reject", done, 1);
            @(negedge clk);
            check(!bus_cmd, "R8", "bus driven later", bus_cmd, 0);
        end else begin
            for (int k = 1; k <= CYCLE; k++) begin
                check(bus_cmd, "R3", "bus_cmd low inside window", bus_cmd, 1);
                check(bus_station == st && bus_sub == sa && bus_func == fn,
                      "R3", "bus address", {bus_station, bus_sub, bus_func}, {st, sa, fn});
                check(bus_wen == wr_fn, "R6", "bus_wen", bus_wen, wr_fn);
                check(bus_wdata == (wr_fn ? wd : 24'h0), "R6", "bus_wdata",
                      bus_wdata, wr_fn ? wd : 24'h0);
                check(!req_ready && !done, "R2", "ready or done during cycle",
                      {req_ready, done}, 0);
                if (k == STROBE) begin
                    bus_rdata = rd; bus_x = x; bus_q = q;
                end else begin
                    bus_rdata = ~rd; bus_x = ~x; bus_q = ~q;
                end
                @(negedge clk);
            end
            check(!bus_cmd && !bus_wen, "R5", "bus released after window",
                  {bus_cmd, bus_wen}, 0);
            check(bus_wdata == 0, "R6", "wdata released", bus_wdata, 0);
            check(done, "R5", "done after release", done, 1);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(!done, "R5", "done pulse ended", done, 0);
        check(req_ready, "R10", "ready after done", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !done && !bus_cmd && !bus_wen, "R1", "state in reset",
              {req_ready, done, bus_cmd, bus_wen}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !done && !bus_cmd && !bus_wen, "R1", "state after reset",
              {req_ready, done, bus_cmd, bus_wen}, 4'b1000);
        // R7 R9: reads with different response combinations
        run_cycle(5'd5,  4'd3,  5'd0,  24'h0,      24'hA5C3F1, 1'b1, 1'b1);
        run_cycle(5'd23, 4'd15, 5'd2,  24'h0,      24'h13579B, 1'b1, 1'b0);
        // R6: write keeps data on the bus, rdata reported as 0
        run_cycle(5'd1,  4'd0,  5'd16, 24'hDEAD42, 24'h777777, 1'b0, 1'b1);
        run_cycle(5'd9,  4'd7,  5'd23, 24'h00FF00, 24'h123456, 1'b1, 1'b1);
        // control function: no data either way
        run_cycle(5'd12, 4'd9,  5'd9,  24'hFFFFFF, 24'hABCDEF, 1'b0, 1'b0);
        run_cycle(5'd17, 4'd1,  5'd26, 24'h0,      24'h654321, 1'b1, 1'b0);
        // R8: out-of-range stations
        run_cycle(5'd0,  4'd2,  5'd0,  24'h0,      24'hFFFFFF, 1'b1, 1'b1);
        run_cycle(5'd24, 4'd2,  5'd16, 24'h111111, 24'hFFFFFF, 1'b1, 1'b1);
        run_cycle(5'd31, 4'd2,  5'd0,  24'h0,      24'hFFFFFF, 1'b1, 1'b1);
        // R10: back-to-back read after reject
        run_cycle(5'd22, 4'd4,  5'd1,  24'h0,      24'h800001, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5", "missing done pulses", exp_q.size(), 0);
        finish_run();
    end
endmodule